// File: doc/BRIEF.md
# Inbound PCI Address Window Translator

This block maps addresses issued by PCI bus masters onto the local memory bus. It holds three inbound windows. Each window has a 64-bit size/enable mask and a 64-bit local base. A 32-bit register port lets software program both values. The lookup side is purely combinational: it takes a 64-bit PCI address and returns a hit flag, the index of the window that claimed the address, and the translated local address.

A window claims the PCI addresses from zero up to its size. The size is the two's complement of the mask after the mask's three lowest bits are cleared. Bit 0 of the mask is the enable. The translated address is the window's local base plus the PCI address. When several windows claim the same address, the window with the lowest index wins. A register write changes the lookup result from the clock cycle that follows the write edge.

Top module: `pci_inbound_xlate`

## Requirements
- R1: After reset, every mask is 0xFFFFFFFF_00000000 and every base is zero. Reading a mask low word or a base word gives 0, and reading a mask high word gives 0xFFFFFFFF. No address hits.
- R2: The register map uses byte offsets. Window 0 has mask low at 0x98, mask high at 0xF8, base low at 0x9C and base high at 0xA0. Window 1 has its mask at 0xA4, base low at 0xA8 and base high at 0xAC. Window 2 has mask low at 0xB0, mask high at 0xFC, base low at 0xB4 and base high at 0xB8. Each register reads back the 32-bit half it holds.
- R3: A write to one 32-bit half of a mask or a base leaves the other half unchanged.
- R4: Window 1 has only one 32-bit mask register. A write to it replaces the whole 64-bit mask, so the upper 32 bits become zero.
- R5: Mask bit 0 enables the window. A window whose bit 0 is clear never hits.
- R6: An enabled window hits when the PCI address is below size = (~(mask & ~7) + 1) mod 2^64. A size of zero means the window covers all 2^64 addresses. Mask bits 2:1 have no effect.
- R7: On a hit, the local address is the window's base plus the PCI address, modulo 2^64.
- R8: When more than one enabled window hits, the lowest window index wins. The 2-bit window output carries that index.
- R9: When no window hits, the hit output is 0, the window output is 0 and the local address output is 0.
- R10: An offset outside the map, or one that is not a multiple of 4, reads as 0. A write to such an offset changes no register.
- R11: A register write is seen by lookups from the cycle that follows the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pci_addr | input | 64 | PCI address to translate |
| lk_hit | output | 1 | Some enabled window claims pci_addr |
| lk_win | output | 2 | Index of the winning window |
| lk_local | output | 64 | Translated local address |

## Verification
The hardest cases to reach from the ports are the window edges. An address equal to size - 1 must hit and an address equal to size must miss. Random addresses almost never land on those points. The bench therefore keeps its own copy of the registers and computes each window's size from it. It then drives the last address inside each window and the first address outside it. It also programs nested windows so that priority decides the result, and it writes window 1's single mask register so that the window spans the whole address space.

// File: rtl/inb_pkg.sv
package inb_pkg;
  localparam int NWIN   = 3;
  localparam int AW     = 64;
  localparam int DW     = 32;
  localparam int OFFW   = 8;
  localparam int WIDX   = $clog2(NWIN);
  localparam logic [AW-1:0] MASK_RST = {{(AW-DW){1'b1}}, {DW{1'b0}}};

  typedef enum logic [2:0] {
    FLD_NONE, FLD_MASK_LO, FLD_MASK_HI, FLD_MASK_W32, FLD_BASE_LO, FLD_BASE_HI
  } fld_e;

  typedef struct packed {
    logic [WIDX-1:0] win;
    fld_e            fld;
  } dec_t;

  function automatic dec_t reg_decode(input logic [OFFW-1:0] off);
    dec_t d;
    d.win = '0;
    d.fld = FLD_NONE;
    case (off)
      8'h98: begin d.win = 2'd0; d.fld = FLD_MASK_LO;  end
      8'hF8: begin d.win = 2'd0; d.fld = FLD_MASK_HI;  end
      8'h9C: begin d.win = 2'd0; d.fld = FLD_BASE_LO;  end
      8'hA0: begin d.win = 2'd0; d.fld = FLD_BASE_HI;  end
      8'hA4: begin d.win = 2'd1; d.fld = FLD_MASK_W32; end
      8'hA8: begin d.win = 2'd1; d.fld = FLD_BASE_LO;  end
      8'hAC: begin d.win = 2'd1; d.fld = FLD_BASE_HI;  end
      8'hB0: begin d.win = 2'd2; d.fld = FLD_MASK_LO;  end
      8'hFC: begin d.win = 2'd2; d.fld = FLD_MASK_HI;  end
      8'hB4: begin d.win = 2'd2; d.fld = FLD_BASE_LO;  end
      8'hB8: begin d.win = 2'd2; d.fld = FLD_BASE_HI;  end
      default: ;
    endcase
    return d;
  endfunction

  // Highest address a window covers: size - 1, which is the inverted masked value.
  function automatic logic [AW-1:0] win_limit(input logic [AW-1:0] m);
    return ~{m[AW-1:3], 3'b000};
  endfunction
endpackage

// File: rtl/inb_regs.sv
module inb_regs
  import inb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [OFFW-1:0]           addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic [NWIN-1:0][AW-1:0]   mask_o,
  output logic [NWIN-1:0][AW-1:0]   base_o
);
  logic [NWIN-1:0][AW-1:0] mask_q, base_q;
  dec_t dec;
  logic wr_mapped;

  assign dec       = reg_decode(addr);
  assign wr_mapped = we && (dec.fld != FLD_NONE);
  assign mask_o    = mask_q;
  assign base_o    = base_q;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel;
    assign sel = wr_mapped && (dec.win == w);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[w] <= MASK_RST;
        base_q[w] <= '0;
      end else if (sel) begin
        case (dec.fld)
          FLD_MASK_LO:  mask_q[w][DW-1:0]  <= wdata;
          FLD_MASK_HI:  mask_q[w][AW-1:DW] <= wdata;
          FLD_MASK_W32: mask_q[w]          <= {{(AW-DW){1'b0}}, wdata};
          FLD_BASE_LO:  base_q[w][DW-1:0]  <= wdata;
          FLD_BASE_HI:  base_q[w][AW-1:DW] <= wdata;
          default: ;
        endcase
      end
    end

    a_r3_base_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      sel && dec.fld == FLD_BASE_LO |=> $stable(base_q[w][AW-1:DW]));
    a_r3_mask_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      sel && dec.fld == FLD_MASK_HI |=> $stable(mask_q[w][DW-1:0]));
    a_r4_w32_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
      sel && dec.fld == FLD_MASK_W32 |=> mask_q[w][AW-1:DW] == '0);
  end

  always_comb begin
    rdata = '0;
    if (dec.fld != FLD_NONE && int'(dec.win) < NWIN) begin
      case (dec.fld)
        FLD_MASK_LO, FLD_MASK_W32: rdata = mask_q[dec.win][DW-1:0];
        FLD_MASK_HI:               rdata = mask_q[dec.win][AW-1:DW];
        FLD_BASE_LO:               rdata = base_q[dec.win][DW-1:0];
        FLD_BASE_HI:               rdata = base_q[dec.win][AW-1:DW];
        default:                   rdata = '0;
      endcase
    end
  end

  a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    we && dec.fld == FLD_NONE |=> $stable(mask_q) && $stable(base_q));
  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec.fld == FLD_NONE |-> rdata == '0);
endmodule

// File: rtl/inb_window.sv
module inb_window
  import inb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pci_addr,
  output logic          hit,
  output logic [AW-1:0] xlat
);
  logic          enabled;
  logic [AW-1:0] limit;

  assign enabled = mask[0];
  assign limit   = win_limit(mask);
  assign hit     = enabled && (pci_addr <= limit);
  assign xlat    = base + pci_addr;

  a_r5_disabled_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[0] |-> !hit);
  a_r6_zero_addr_hits_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    mask[0] && pci_addr == '0 |-> hit);
endmodule

// File: rtl/inb_select.sv
module inb_select
  import inb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWIN-1:0]         hit_vec,
  input  logic [NWIN-1:0][AW-1:0] xlat_vec,
  output logic                    hit,
  output logic [WIDX-1:0]         win,
  output logic [AW-1:0]           local_addr
);
  logic [NWIN-1:0] lower_mask;

  always_comb begin
    hit        = 1'b0;
    win        = '0;
    local_addr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit        = 1'b1;
        win        = WIDX'(i);
        local_addr = xlat_vec[i];
      end
    end
  end

  assign lower_mask = (NWIN'(1) << win) - NWIN'(1);

  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_vec[win] && ((hit_vec & lower_mask) == '0));
  a_r9_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> local_addr == '0 && win == '0 && hit_vec == '0);
endmodule

// File: rtl/pci_inbound_xlate.sv
module pci_inbound_xlate
  import inb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [63:0]   pci_addr,
  output logic          lk_hit,
  output logic [1:0]    lk_win,
  output logic [63:0]   lk_local
);
  logic [NWIN-1:0][AW-1:0] mask_w, base_w, xlat_w;
  logic [NWIN-1:0]         hit_w;

  inb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .mask_o(mask_w), .base_o(base_w)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_lookup
    inb_window u_win (
      .clk(clk), .rst_n(rst_n), .mask(mask_w[w]), .base(base_w[w]),
      .pci_addr(pci_addr), .hit(hit_w[w]), .xlat(xlat_w[w])
    );
  end

  inb_select u_sel (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_w), .xlat_vec(xlat_w),
    .hit(lk_hit), .win(lk_win), .local_addr(lk_local)
  );

  a_r1_reset_no_hit: assert property (@(posedge clk)
    $past(!rst_n) && rst_n |-> !lk_hit);
endmodule

// File: tb/pci_inbound_xlate_test.sv
`timescale 1ns/1ps
module pci_inbound_xlate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [63:0] pci_addr = 0;
  logic        lk_hit;
  logic [1:0]  lk_win;
  logic [63:0] lk_local;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_mask [3];
  logic [63:0] m_base [3];

  always #2.5 clk = ~clk;

  pci_inbound_xlate uut (.*);

  function automatic logic [7:0] off_of(int k);
    logic [7:0] t [11] = '{8'h98, 8'hF8, 8'h9C, 8'hA0, 8'hA4, 8'hA8,
                           8'hAC, 8'hB0, 8'hFC, 8'hB4, 8'hB8};
    return t[k];
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h98: return m_mask[0][31:0];  8'hF8: return m_mask[0][63:32];
      8'h9C: return m_base[0][31:0];  8'hA0: return m_base[0][63:32];
      8'hA4: return m_mask[1][31:0];
      8'hA8: return m_base[1][31:0];  8'hAC: return m_base[1][63:32];
      8'hB0: return m_mask[2][31:0];  8'hFC: return m_mask[2][63:32];
      8'hB4: return m_base[2][31:0];  8'hB8: return m_base[2][63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h98: m_mask[0][31:0] = d;  8'hF8: m_mask[0][63:32] = d;
      8'h9C: m_base[0][31:0] = d;  8'hA0: m_base[0][63:32] = d;
      8'hA4: m_mask[1] = {32'h0, d};
      8'hA8: m_base[1][31:0] = d;  8'hAC: m_base[1][63:32] = d;
      8'hB0: m_mask[2][31:0] = d;  8'hFC: m_mask[2][63:32] = d;
      8'hB4: m_base[2][31:0] = d;  8'hB8: m_base[2][63:32] = d;
      default: ;
    endcase
  endfunction

  function automatic bit win_hits(int w, logic [63:0] a);
    logic [63:0] sz;
    sz = ~(m_mask[w] & ~64'd7) + 64'd1;
    if (!m_mask[w][0]) return 0;
    return (sz == 64'd0) || (a < sz);
  endfunction

  function automatic logic [63:0] win_size(int w);
    return ~(m_mask[w] & ~64'd7) + 64'd1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    model_write(a, d);
  endtask

  task automatic rd_check(string req, logic [7:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, {32'h0, reg_rdata}, {32'h0, exp_read(a)});
  endtask

  task automatic look(string req, logic [63:0] a);
    bit h; int wi; logic [63:0] loc;
    h = 0; wi = 0; loc = 0;
    for (int w = 2; w >= 0; w--)
      if (win_hits(w, a)) begin h = 1; wi = w; loc = m_base[w] + a; end
    @(negedge clk);
    pci_addr = a;
    #1;
    check({req, " hit"}, {63'h0, lk_hit}, {63'h0, h});
    check({req, " win"}, {62'h0, lk_win}, 64'(wi));
    check({req, " local"}, lk_local, loc);
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < 11; k++) rd_check(req, off_of(k));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < 3; w++) begin m_mask[w] = 64'hFFFF_FFFF_0000_0000; m_base[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    read_all("R1 reset read");
    look("R1 reset lookup", 64'h0);
    look("R1 reset lookup", 64'h1234);

    // R2/R11: window 0 4 KiB, base high, visible next cycle
    wr(8'h98, 32'hFFFF_F001);
    wr(8'h9C, 32'h8000_0000);
    wr(8'hA0, 32'h0000_0002);
    read_all("R2 map read");
    look("R11 after write", 64'h10);
    // R6 boundary, bits 2:1 ignored
    look("R6 last inside", 64'hFFF);
    look("R6 first outside", 64'h1000);
    wr(8'h98, 32'hFFFF_F007);
    look("R6 low bits ignored", 64'hFFF);
    look("R6 low bits ignored", 64'h1000);
    // R5 disable
    wr(8'h98, 32'hFFFF_F000);
    look("R5 disabled", 64'h4);
    // R3 half writes
    wr(8'hF8, 32'h1234_5678);
    rd_check("R3 mask low kept", 8'h98);
    wr(8'h9C, 32'h0000_1000);
    rd_check("R3 base high kept", 8'hA0);
    wr(8'hF8, 32'hFFFF_FFFF);
    wr(8'h98, 32'hFFFF_0001);
    // R4 window 1 single mask: full range
    wr(8'hA4, 32'h0000_0001);
    rd_check("R4 w1 mask read", 8'hA4);
    wr(8'hA8, 32'hFFFF_FFFF); wr(8'hAC, 32'hFFFF_FFFF);
    look("R4 whole space", 64'hFFFF_FFFF_FFFF_FFF0);
    look("R7 wraps", 64'h0001_0000_0000_0005);
    // R8 priority: window 0 (64 KiB) beats window 1
    look("R8 low index wins", 64'h100);
    look("R8 fallthrough", 64'h10000);
    // R9 miss
    wr(8'hA4, 32'hFFFF_FF00);
    look("R9 miss zero", 64'h20000);
    // R10 unmapped / unaligned writes ignored
    wr(8'h99, 32'hDEAD_BEEF);
    wr(8'hE0, 32'hDEAD_BEEF);
    wr(8'h00, 32'hDEAD_BEEF);
    read_all("R10 unmapped write ignored");
    rd_check("R10 unmapped read", 8'h9A);
    rd_check("R10 unmapped read", 8'hF0);
    look("R10 lookup unchanged", 64'h100);

    // Random mix with boundary targeting (R6, R7, R8)
    for (int it = 0; it < 400; it++) begin
      int op; op = $urandom_range(0, 9);
      if (op < 4) begin
        int k; logic [31:0] d; k = $urandom_range(0, 10);
        d = $urandom;
        if (off_of(k) == 8'h98 || off_of(k) == 8'hB0 || off_of(k) == 8'hA4)
          d = (32'hFFFF_FFFF << $urandom_range(3, 31)) | 32'($urandom_range(0, 7));
        else if (off_of(k) == 8'hF8 || off_of(k) == 8'hFC)
          d = ($urandom_range(0, 3) == 0) ? $urandom : 32'hFFFF_FFFF;
        wr(off_of(k), d);
      end else if (op < 5) begin
        rd_check("R2 random read", off_of($urandom_range(0, 10)));
      end else begin
        int w; logic [63:0] a; w = $urandom_range(0, 2);
        case ($urandom_range(0, 3))
          0: a = win_size(w) - 64'd1;
          1: a = win_size(w);
          2: a = 64'($urandom_range(0, 4095));
          default: a = {$urandom, $urandom};
        endcase
        look("R6 R7 R8 random", a);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule